// File: doc/BRIEF.md
# Reserved-Slot Key Slot Allocator

This block hands out hardware key slot numbers to clients and takes them back when the clients are done. It keeps the unused slots in a small circular list and reuses them strictly first-in first-out. An allocate request takes the oldest free slot. A release puts a slot back behind all the others. If no slot is free, the allocate request gets a failure pulse and no slot.

One slot number is kept back for a secure key loaded at boot. It is never in the free list and is never granted. A release that names it is dropped without any error. A release that names a slot already in the free list is reported as an error and is not added a second time. When an allocate and a release come in the same cycle, the release is applied first. So an empty pool can still grant the slot that is being returned in that cycle.

All responses come from registers and appear in the cycle after the request. Each response is a single-cycle pulse.

Top module: `keyslot_pool`

## Requirements
- R1: After reset all outputs are low, and the free list holds slots 0, 1, 2, 3, 5, 6, 7 with slot 0 at the head. Successive allocations therefore return them in that ascending order.
- R2: In the cycle after an allocate request (alloc_req high at a clock edge) with a non-empty pool, alloc_gnt is high for exactly one cycle and alloc_slot carries the slot at the head of the free list. That slot leaves the pool.
- R3: An allocate request with an empty pool and no usable release in the same cycle gives a one-cycle alloc_fail pulse in the next cycle. alloc_gnt stays low and alloc_slot reads 0.
- R4: A release (rel_req high with slot number rel_slot) of a slot that is not in the pool appends that slot at the tail. Later grants follow release order.
- R5: Slot 4 is reserved. A release of slot 4 raises no error and leaves the pool unchanged, and slot 4 is never granted.
- R6: A release of a slot that is already in the pool gives a one-cycle rel_err pulse in the next cycle and adds no second entry.
- R7: When an allocate and a release arrive in the same cycle, the release is applied before the allocate. An empty pool then grants the released slot, and a non-empty pool grants its old head while the released slot goes to the tail.
- R8: alloc_gnt and alloc_fail are never high together. Neither pulses without an allocate request in the cycle before, and alloc_slot reads 0 whenever alloc_gnt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocate one slot this cycle |
| rel_req | input | 1 | Return the slot on rel_slot this cycle |
| rel_slot | input | 3 | Slot number being returned |
| alloc_gnt | output | 1 | One-cycle pulse: a slot was granted |
| alloc_fail | output | 1 | One-cycle pulse: allocate found no free slot |
| alloc_slot | output | 3 | Granted slot number, 0 when no grant |
| rel_err | output | 1 | One-cycle pulse: released slot was already free |

## Verification
The bench drains the full pool and checks the ascending start order. A wrong reset image would show up as a slot out of order or as a grant of slot 4. It requests from an empty pool, where a broken empty test would grant a stale head entry. It returns the reserved slot and then drains again; a missing exclusion would then let slot 4 out. It repeats a release of a free slot, which would otherwise give a double grant or a missing error pulse. It also allocates and releases together on both an empty and a non-empty pool. A design that applied the two in the wrong order would report a failure where a grant is due, or would hand back the wrong slot.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;

  // Slot held at list position pos after reset: ascending, skipping the reserved number.
  function automatic int unsigned pool_init_slot(input int unsigned pos, input int unsigned rsvd);
    return (pos < rsvd) ? pos : pos + 1;
  endfunction

  typedef struct packed {
    logic gnt;
    logic fail;
    logic err;
  } pool_flags_t;

endpackage

// File: rtl/keyslot_ring.sv
module keyslot_ring #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_slot,
  input  logic              pop,
  output logic [SLOT_W-1:0] head_slot,
  output logic              nonempty
);
  import keyslot_pkg::*;

  localparam int unsigned DEPTH = NUM_SLOTS - 1;
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SLOT_W-1:0] ent_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // entry storage, reset to the initial free list
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [SLOT_W-1:0] INIT_VAL = SLOT_W'(pool_init_slot(i, RSVD_SLOT));
    logic             wr_en;
    logic [SLOT_W-1:0] val_q;
    assign wr_en = push && (tail_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= INIT_VAL;
      end else if (wr_en) begin
        val_q <= push_slot;
      end
    end
    assign ent_q[i] = val_q;
  end

  // next state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = ptr_inc(tail_q);
    if (pop)  head_d = ptr_inc(head_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= FULL_CNT;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // an empty list forwards the slot being pushed in the same cycle
  assign nonempty  = (cnt_q != '0);
  assign head_slot = nonempty ? ent_q[head_q] : push_slot;

endmodule

// File: rtl/keyslot_presence.sv
module keyslot_presence #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [SLOT_W-1:0]    set_idx,
  input  logic                 clr_en,
  input  logic [SLOT_W-1:0]    clr_idx,
  output logic [NUM_SLOTS-1:0] present
);

  logic [NUM_SLOTS-1:0] pres_q, pres_d;

  // a slot set and cleared in one cycle ends up cleared (release before allocate)
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      pres_d[i] = (pres_q[i] | (set_en && (set_idx == SLOT_W'(i))))
                  & ~(clr_en && (clr_idx == SLOT_W'(i)));
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
    localparam logic INIT_BIT = (i != RSVD_SLOT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[i] <= INIT_BIT;
      end else begin
        pres_q[i] <= pres_d[i];
      end
    end
  end

  assign present = pres_q;

endmodule

// File: rtl/keyslot_resp.sv
module keyslot_resp #(
  parameter int unsigned SLOT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  keyslot_pkg::pool_flags_t flags_d,
  input  logic [SLOT_W-1:0]        slot_d,
  output keyslot_pkg::pool_flags_t flags_q,
  output logic [SLOT_W-1:0]        slot_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      slot_q  <= '0;
    end else begin
      flags_q <= flags_d;
      slot_q  <= slot_d;
    end
  end

endmodule

// File: rtl/keyslot_pool.sv
module keyslot_pool #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              rel_req,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              alloc_gnt,
  output logic              alloc_fail,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              rel_err
);
  import keyslot_pkg::*;

  localparam logic [SLOT_W-1:0] RSVD_ID = SLOT_W'(RSVD_SLOT);

  logic [NUM_SLOTS-1:0] present;
  logic                 rsvd_hit, in_range, rel_live;
  logic                 rel_ok, rel_dup;
  logic                 ring_nz, take;
  logic [SLOT_W-1:0]    head_slot, slot_d;
  pool_flags_t          flags_d, flags_q;

  // release decode: reserved and out-of-range numbers drop silently
  assign rsvd_hit = (rel_slot == RSVD_ID);
  assign in_range = (32'(rel_slot) < NUM_SLOTS);
  assign rel_live = rel_req && !rsvd_hit && in_range;
  assign rel_dup  = rel_live && present[rel_slot];
  assign rel_ok   = rel_live && !present[rel_slot];

  // allocate sees the pool after this cycle's release
  assign take = alloc_req && (ring_nz || rel_ok);

  always_comb begin
    flags_d.gnt  = take;
    flags_d.fail = alloc_req && !take;
    flags_d.err  = rel_dup;
    slot_d       = take ? head_slot : '0;
  end

  keyslot_ring #(
    .NUM_SLOTS(NUM_SLOTS),
    .RSVD_SLOT(RSVD_SLOT)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rel_ok),
    .push_slot(rel_slot),
    .pop      (take),
    .head_slot(head_slot),
    .nonempty (ring_nz)
  );

  keyslot_presence #(
    .NUM_SLOTS(NUM_SLOTS),
    .RSVD_SLOT(RSVD_SLOT)
  ) u_pres (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (rel_ok),
    .set_idx(rel_slot),
    .clr_en (take),
    .clr_idx(head_slot),
    .present(present)
  );

  keyslot_resp #(
    .SLOT_W(SLOT_W)
  ) u_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags_d(flags_d),
    .slot_d (slot_d),
    .flags_q(flags_q),
    .slot_q (alloc_slot)
  );

  assign alloc_gnt  = flags_q.gnt;
  assign alloc_fail = flags_q.fail;
  assign rel_err    = flags_q.err;

endmodule

// File: rtl/keyslot_pool_chk.sv
module keyslot_pool_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_req,
  input logic              rel_req,
  input logic [SLOT_W-1:0] rel_slot,
  input logic              alloc_gnt,
  input logic              alloc_fail,
  input logic [SLOT_W-1:0] alloc_slot,
  input logic              rel_err
);

  // R8
  gnt_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_gnt && alloc_fail));

  // R2
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !alloc_gnt);

  // R3
  fail_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !alloc_fail);

  // R2
  req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (alloc_gnt || alloc_fail));

  // R5
  rsvd_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> (alloc_slot != SLOT_W'(RSVD_SLOT)));

  // R8
  idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_gnt |-> (alloc_slot == '0));

  // R6
  err_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_req && (rel_slot != SLOT_W'(RSVD_SLOT))) |=> !rel_err);

  // R5
  rsvd_release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && (rel_slot == SLOT_W'(RSVD_SLOT))) |=> !rel_err);

endmodule

bind keyslot_pool keyslot_pool_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .RSVD_SLOT(RSVD_SLOT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alloc_req (alloc_req),
  .rel_req   (rel_req),
  .rel_slot  (rel_slot),
  .alloc_gnt (alloc_gnt),
  .alloc_fail(alloc_fail),
  .alloc_slot(alloc_slot),
  .rel_err   (rel_err)
);

// File: tb/keyslot_pool_bench.sv
`timescale 1ns/1ps
module keyslot_pool_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0;
  logic       rel_req = 1'b0;
  logic [2:0] rel_slot = 3'd0;
  logic       alloc_gnt, alloc_fail, rel_err;
  logic [2:0] alloc_slot;

  int vectors = 0;
  int miscompares = 0;
  int pool[$];
  int unsigned lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  keyslot_pool u_keyslot_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .rel_req   (rel_req),
    .rel_slot  (rel_slot),
    .alloc_gnt (alloc_gnt),
    .alloc_fail(alloc_fail),
    .alloc_slot(alloc_slot),
    .rel_err   (rel_err)
  );

  function automatic bit in_pool(input int s);
    foreach (pool[i]) if (pool[i] == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare(input string tag, input bit eg, input bit ef, input int es, input bit ee);
    vectors++;
    if (alloc_gnt !== eg || alloc_fail !== ef || int'(alloc_slot) != es || rel_err !== ee) begin
      miscompares++;
      $display("FAIL %s: gnt/fail/slot/err actual %b/%b/%0d/%b expected %b/%b/%0d/%b",
               tag, alloc_gnt, alloc_fail, alloc_slot, rel_err, eg, ef, es, ee);
    end
  endtask

  // one cycle: drive, update the model (release first), then check after the edge
  task automatic step(input bit a, input bit r, input int rs, input string tag_in);
    bit eg = 0, ef = 0, ee = 0;
    int es = 0;
    string tag = tag_in;
    alloc_req = a;
    rel_req   = r;
    rel_slot  = 3'(rs);
    if (r && rs != 4) begin
      if (in_pool(rs)) ee = 1;
      else pool.push_back(rs);
    end
    if (a) begin
      if (pool.size() > 0) begin eg = 1; es = pool.pop_front(); end
      else ef = 1;
    end
    if (tag == "") begin
      if (ee) tag = "R6";
      else if (a && r) tag = "R7";
      else if (ef) tag = "R3";
      else if (eg) tag = "R2";
      else if (r && rs == 4) tag = "R5";
      else tag = "R4";
    end
    @(posedge clk);
    #1;
    compare(tag, eg, ef, es, ee);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    pool = '{0, 1, 2, 3, 5, 6, 7};
    repeat (3) @(posedge clk);
    #1;
    compare("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0, "R8");
    // R1: ascending drain, slot 4 absent
    for (int k = 0; k < 7; k++) step(1, 0, 0, "R1");
    step(1, 0, 0, "R3");
    // R4/R5/R6 returns
    step(0, 1, 6, "R4");
    step(0, 1, 2, "R4");
    step(0, 1, 4, "R5");
    step(0, 1, 6, "R6");
    step(1, 0, 0, "R4");
    step(1, 0, 0, "R4");
    step(1, 0, 0, "R5");
    // R7 on empty pool, then on non-empty pool
    step(1, 1, 3, "R7");
    step(0, 1, 0, "R4");
    step(0, 1, 1, "R4");
    step(1, 1, 5, "R7");
    step(0, 0, 0, "R8");
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step(lcg[20] | lcg[21], lcg[22], int'(lcg[26:24]), "");
    end
    step(0, 0, 0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule